// File: doc/BRIEF.md
# Debounced 8x8 Key Matrix Scanner

This block walks an 8-by-8 array of normally open switches. It pulls one column low at a time and reads the rows through pull-ups, so a closed switch reads as a low row. After one pass over all eight columns it has a full 64-bit picture of which keys are closed. That picture counts as settled only when the same picture comes back on several back-to-back passes. A settled picture with no more than two keys is turned into key codes. A key interrupt is raised whenever that settled picture differs from the one last reported.

A programmable chord of three keys raises a second, separate interrupt. It fires once for each time the chord settles. A picture with three or more keys that is not the chord is dropped. When the enable is low, the block drives no column and ignores the rows, so the sixteen matrix pins can be used for general-purpose I/O.

Top module: `keypad_scanner`

## Requirements
- R1: While enabled, exactly one column output is driven at a time: `col_oe` has a single bit set and the same bit is low in `col_drive_n`. Columns are visited in order 0 to 7, and each is held for `slot_len` clocks (0 acts as 1). A low row input means the key at that row and column is closed.
- R2: A key picture is settled after N identical consecutive full passes, where N is `stable_scans` and the value 0 selects N = 3. A picture that changes between passes is never reported.
- R3: `key_irq` goes high when a settled picture of at most two keys differs from the last reported picture (initially empty). It stays high until cleared. A settled picture equal to the reported one raises nothing.
- R4: A key code is 6 bits wide, equal to row*8 + column. Slot 0 (`key0_code`/`key0_valid`) holds the lower code and slot 1 holds the higher code. With one key, only slot 0 is valid. With no keys, neither slot is valid.
- R5: A settled picture of three or more keys that is not exactly the chord leaves both code slots and `key_irq` unchanged.
- R6: A settled picture equal to exactly the three keys `chord_a`, `chord_b` and `chord_c` sets `reset_irq` and leaves the code slots and `key_irq` unchanged. Holding the chord after a clear does not set it again. Releasing the chord and pressing it again does set it again.
- R7: While `enable` is low, `col_oe` is all zeros and `col_drive_n` all ones, the rows have no effect, and the code slots and interrupts hold their values. Scanning restarts from column 0 when `enable` returns high.
- R8: After reset, both code slots are invalid with code 0 and both interrupts are low.
- R9: A high `key_irq_clr` or `reset_irq_clr` drops the matching interrupt on the next clock, unless a new event sets it in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Scanner on; low releases the matrix pins |
| slot_len | input | 8 | Clocks per column slot (0 acts as 1) |
| stable_scans | input | 4 | Identical passes needed (0 selects 3) |
| chord_a | input | 6 | First chord key code |
| chord_b | input | 6 | Second chord key code |
| chord_c | input | 6 | Third chord key code |
| row_sense_n | input | 8 | Row inputs, low when a key conducts |
| col_drive_n | output | 8 | Column drive values, active low |
| col_oe | output | 8 | Column output enables |
| key0_code | output | 6 | Lower decoded key code |
| key0_valid | output | 1 | Slot 0 holds a key |
| key1_code | output | 6 | Higher decoded key code |
| key1_valid | output | 1 | Slot 1 holds a key |
| key_irq | output | 1 | New settled key picture |
| key_irq_clr | input | 1 | Clears key_irq |
| reset_irq | output | 1 | Reset chord detected |
| reset_irq_clr | input | 1 | Clears reset_irq |

## Verification
The hardest case to reach is the once-per-assertion rule for the chord. Showing that a held chord does not fire again needs several settled passes after the clear. Showing that it fires again needs a full release, a settle of the released picture, and a fresh settle of the chord.

The bench drives the rows from a model of the key array that reacts to the block's own column outputs. It then holds each picture for several whole pass times before it samples. Debounce is exercised in two ways: a key that toggles every pass, and a raised threshold with a hold just short of it.

// File: rtl/kp_pkg.sv
package kp_pkg;
    localparam int ROWS   = 8;
    localparam int COLS   = 8;
    localparam int KEYS   = ROWS * COLS;
    localparam int CODE_W = $clog2(KEYS);
    localparam int COL_W  = $clog2(COLS);

    typedef logic [KEYS-1:0] key_map_t;

    typedef struct packed {
        logic              valid;
        logic [CODE_W-1:0] code;
    } key_slot_t;

    // Number of set bits, saturating at 3 (enough to tell 0,1,2,many)
    function automatic logic [1:0] count_sat3(input key_map_t m);
        logic [1:0] n;
        n = 2'd0;
        for (int i = 0; i < KEYS; i++)
            if (m[i] && n != 2'd3) n = n + 2'd1;
        return n;
    endfunction

    // Lowest set bit as a key slot; invalid when map is empty
    function automatic key_slot_t lowest_key(input key_map_t m);
        key_slot_t s;
        s = '0;
        for (int i = KEYS - 1; i >= 0; i--)
            if (m[i]) begin
                s.valid = 1'b1;
                s.code  = CODE_W'(i);
            end
        return s;
    endfunction

    function automatic key_map_t code_bit(input logic [CODE_W-1:0] c);
        key_map_t m;
        m = '0;
        m[c] = 1'b1;
        return m;
    endfunction
endpackage

// File: rtl/kp_col_scan.sv
module kp_col_scan
    import kp_pkg::*;
#(
    parameter int SLOT_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              enable,
    input  logic [SLOT_W-1:0] slot_len,
    input  logic [ROWS-1:0]   row_sense_n,
    output logic [COLS-1:0]   col_drive_n,
    output logic [COLS-1:0]   col_oe,
    output logic              frame_done,
    output key_map_t          frame
);
    logic [SLOT_W-1:0] slot_cnt;
    logic [SLOT_W-1:0] slot_max;
    logic [COL_W-1:0]  col;
    key_map_t          acc;
    key_map_t          col_bits;
    logic              slot_end;

    assign slot_max = (slot_len == '0) ? '0 : slot_len - SLOT_W'(1);
    assign slot_end = enable && (slot_cnt == slot_max);

    always_comb begin
        col_bits = '0;
        for (int r = 0; r < ROWS; r++)
            col_bits[r*COLS + int'(col)] = ~row_sense_n[r];
    end

    always_comb begin
        col_oe      = '0;
        col_drive_n = '1;
        if (enable) begin
            col_oe[col]      = 1'b1;
            col_drive_n[col] = 1'b0;
        end
    end

    assign frame_done = slot_end && (col == COL_W'(COLS - 1));
    assign frame      = acc | col_bits;

    always_ff @(posedge clk) begin
        if (rst || !enable) begin
            slot_cnt <= '0;
            col      <= '0;
            acc      <= '0;
        end else if (slot_end) begin
            slot_cnt <= '0;
            col      <= (col == COL_W'(COLS - 1)) ? '0 : col + COL_W'(1);
            acc      <= (col == COL_W'(COLS - 1)) ? '0 : (acc | col_bits);
        end else begin
            slot_cnt <= slot_cnt + SLOT_W'(1);
        end
    end

    // R1: the column only moves at the end of a slot
    a_r1_col_hold: assert property (@(posedge clk) disable iff (rst)
        (enable && $past(enable) && !$past(slot_end)) |-> $stable(col));

    // R7: a disabled scanner restarts from column 0
    a_r7_restart: assert property (@(posedge clk) disable iff (rst)
        ($rose(enable)) |-> (col == '0 && slot_cnt == '0));
endmodule

// File: rtl/kp_debounce.sv
module kp_debounce
    import kp_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     enable,
    input  logic [3:0] stable_scans,
    input  logic     frame_done,
    input  key_map_t frame,
    output logic     settled,
    output key_map_t settled_map
);
    key_map_t   prev;
    logic [4:0] run;
    logic [4:0] run_next;
    logic [4:0] need;
    logic       same;

    assign need     = (stable_scans == 4'd0) ? 5'd3 : {1'b0, stable_scans};
    assign same     = (frame == prev) && (run != 5'd0);
    assign run_next = !same ? 5'd1 : (run == 5'd16 ? 5'd16 : run + 5'd1);

    assign settled     = frame_done && (run_next == need);
    assign settled_map = frame;

    always_ff @(posedge clk) begin
        if (rst || !enable) begin
            prev <= '0;
            run  <= '0;
        end else if (frame_done) begin
            prev <= frame;
            run  <= run_next;
        end
    end

    // R2: a settled event never follows a changed pass when N exceeds 1
    a_r2_run_needed: assert property (@(posedge clk) disable iff (rst)
        (settled && need > 5'd1) |-> (frame == prev));
endmodule

// File: rtl/kp_decode.sv
module kp_decode
    import kp_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              settled,
    input  key_map_t          settled_map,
    input  logic [CODE_W-1:0] chord_a,
    input  logic [CODE_W-1:0] chord_b,
    input  logic [CODE_W-1:0] chord_c,
    input  logic              key_irq_clr,
    input  logic              reset_irq_clr,
    output key_slot_t         slot0,
    output key_slot_t         slot1,
    output logic              key_irq,
    output logic              reset_irq
);
    key_map_t   reported;
    key_map_t   chord_map;
    key_map_t   rest_map;
    key_slot_t  lo_key;
    key_slot_t  hi_key;
    logic [1:0] nkeys;
    logic       chord_hit;
    logic       new_set;

    assign chord_map = code_bit(chord_a) | code_bit(chord_b) | code_bit(chord_c);
    assign nkeys     = count_sat3(settled_map);
    assign lo_key    = lowest_key(settled_map);
    assign rest_map  = lo_key.valid ? (settled_map & ~code_bit(lo_key.code)) : '0;
    assign hi_key    = lowest_key(rest_map);
    assign chord_hit = settled && (settled_map == chord_map);
    assign new_set   = settled && !chord_hit && (nkeys != 2'd3)
                       && (settled_map != reported);

    always_ff @(posedge clk) begin
        if (rst) begin
            reported  <= '0;
            slot0     <= '0;
            slot1     <= '0;
            key_irq   <= 1'b0;
            reset_irq <= 1'b0;
        end else begin
            if (new_set) begin
                reported <= settled_map;
                slot0    <= lo_key;
                slot1    <= hi_key;
                key_irq  <= 1'b1;
            end else if (key_irq_clr) begin
                key_irq  <= 1'b0;
            end
            if (chord_hit)          reset_irq <= 1'b1;
            else if (reset_irq_clr) reset_irq <= 1'b0;
        end
    end

    // R4: slot 1 is only used together with slot 0, and holds the higher code
    a_r4_slot_order: assert property (@(posedge clk) disable iff (rst)
        slot1.valid |-> (slot0.valid && slot1.code > slot0.code));

    // R3: a pending key interrupt stays until cleared
    a_r3_irq_sticky: assert property (@(posedge clk) disable iff (rst)
        (key_irq && !key_irq_clr) |=> key_irq);

    // R6: the reset interrupt stays until cleared
    a_r6_reset_sticky: assert property (@(posedge clk) disable iff (rst)
        (reset_irq && !reset_irq_clr) |=> reset_irq);

    // R9: clear without a new event drops the key interrupt
    a_r9_clear: assert property (@(posedge clk) disable iff (rst)
        (key_irq_clr && !new_set) |=> !key_irq);

    // R5/R6: codes only change on a reported new set
    a_r5_codes_hold: assert property (@(posedge clk) disable iff (rst)
        !new_set |=> ($stable(slot0) && $stable(slot1)));
endmodule

// File: rtl/keypad_scanner.sv
module keypad_scanner
    import kp_pkg::*;
#(
    parameter int SLOT_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              enable,
    input  logic [SLOT_W-1:0] slot_len,
    input  logic [3:0]        stable_scans,
    input  logic [5:0]        chord_a,
    input  logic [5:0]        chord_b,
    input  logic [5:0]        chord_c,
    input  logic [7:0]        row_sense_n,
    output logic [7:0]        col_drive_n,
    output logic [7:0]        col_oe,
    output logic [5:0]        key0_code,
    output logic              key0_valid,
    output logic [5:0]        key1_code,
    output logic              key1_valid,
    output logic              key_irq,
    input  logic              key_irq_clr,
    output logic              reset_irq,
    input  logic              reset_irq_clr
);
    logic      frame_done;
    key_map_t  frame;
    logic      settled;
    key_map_t  settled_map;
    key_slot_t slot0;
    key_slot_t slot1;

    kp_col_scan #(.SLOT_W(SLOT_W)) u_scan (
        .clk(clk), .rst(rst), .enable(enable), .slot_len(slot_len),
        .row_sense_n(row_sense_n), .col_drive_n(col_drive_n), .col_oe(col_oe),
        .frame_done(frame_done), .frame(frame)
    );

    kp_debounce u_deb (
        .clk(clk), .rst(rst), .enable(enable), .stable_scans(stable_scans),
        .frame_done(frame_done), .frame(frame),
        .settled(settled), .settled_map(settled_map)
    );

    kp_decode u_dec (
        .clk(clk), .rst(rst), .settled(settled), .settled_map(settled_map),
        .chord_a(chord_a), .chord_b(chord_b), .chord_c(chord_c),
        .key_irq_clr(key_irq_clr), .reset_irq_clr(reset_irq_clr),
        .slot0(slot0), .slot1(slot1), .key_irq(key_irq), .reset_irq(reset_irq)
    );

    assign key0_code  = slot0.code;
    assign key0_valid = slot0.valid;
    assign key1_code  = slot1.code;
    assign key1_valid = slot1.valid;

    // R7: no column is driven while disabled
    a_r7_released: assert property (@(posedge clk) disable iff (rst)
        !enable |-> (col_oe == '0 && col_drive_n == '1));

    // R1: while enabled exactly one column is driven
    a_r1_one_col: assert property (@(posedge clk) disable iff (rst)
        enable |-> ($countones(col_oe) == 1 && (col_oe & col_drive_n) == '0));
endmodule

// File: tb/keypad_scanner_tb.sv
module keypad_scanner_tb;
    localparam int CLK_PERIOD = 10;
    localparam int SLOT       = 4;
    localparam int FRAME      = 8 * SLOT;

    typedef struct packed {
        logic [63:0] keys;
        logic        v0;
        logic [5:0]  c0;
        logic        v1;
        logic [5:0]  c1;
        logic        irq;
    } vec_t;

    localparam int NV = 7;
    localparam vec_t TBL [0:NV-1] = '{
        '{64'h1 << 9,                   1'b1, 6'd9,  1'b0, 6'd0,  1'b1},
        '{(64'h1 << 3) | (64'h1 << 60), 1'b1, 6'd3,  1'b1, 6'd60, 1'b1},
        '{(64'h1 << 63) | 64'h1,        1'b1, 6'd0,  1'b1, 6'd63, 1'b1},
        '{64'h0,                        1'b0, 6'd0,  1'b0, 6'd0,  1'b1},
        '{64'h16,                       1'b0, 6'd0,  1'b0, 6'd0,  1'b0},
        '{64'h1 << 17,                  1'b1, 6'd17, 1'b0, 6'd0,  1'b1},
        '{64'h1 << 17,                  1'b1, 6'd17, 1'b0, 6'd0,  1'b0}
    };

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       enable = 1'b0;
    logic [7:0] slot_len = 8'(SLOT);
    logic [3:0] stable_scans = 4'd0;
    logic [5:0] chord_a = 6'd10, chord_b = 6'd20, chord_c = 6'd30;
    logic [7:0] row_sense_n;
    logic [7:0] col_drive_n, col_oe;
    logic [5:0] key0_code, key1_code;
    logic       key0_valid, key1_valid, key_irq, reset_irq;
    logic       key_irq_clr = 1'b0, reset_irq_clr = 1'b0;
    logic [63:0] pressed = '0;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    // key array model: a closed key pulls its row low while its column is driven
    always_comb begin
        for (int r = 0; r < 8; r++) begin
            row_sense_n[r] = 1'b1;
            for (int c = 0; c < 8; c++)
                if (pressed[r*8+c] && col_oe[c] && !col_drive_n[c])
                    row_sense_n[r] = 1'b0;
        end
    end

    keypad_scanner u_dut (
        .clk(clk), .rst(rst), .enable(enable), .slot_len(slot_len),
        .stable_scans(stable_scans), .chord_a(chord_a), .chord_b(chord_b),
        .chord_c(chord_c), .row_sense_n(row_sense_n), .col_drive_n(col_drive_n),
        .col_oe(col_oe), .key0_code(key0_code), .key0_valid(key0_valid),
        .key1_code(key1_code), .key1_valid(key1_valid), .key_irq(key_irq),
        .key_irq_clr(key_irq_clr), .reset_irq(reset_irq),
        .reset_irq_clr(reset_irq_clr)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic wait_frames(input int n);
        repeat (n * FRAME) @(posedge clk);
        #1;
    endtask

    task automatic clr_key();
        key_irq_clr = 1'b1;
        @(posedge clk); #1;
        key_irq_clr = 1'b0;
    endtask

    task automatic clr_reset();
        reset_irq_clr = 1'b1;
        @(posedge clk); #1;
        reset_irq_clr = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(posedge clk); #1;
        // R8 reset state
        chk("R8 key0_valid", 32'(key0_valid), 0);
        chk("R8 key1_valid", 32'(key1_valid), 0);
        chk("R8 key0_code", 32'(key0_code), 0);
        chk("R8 irqs", {30'd0, key_irq, reset_irq}, 0);
        chk("R7 disabled col_oe", 32'(col_oe), 0);

        enable = 1'b1;
        @(posedge clk); #1;
        chk("R1 column 0 first", {24'd0, col_oe}, 32'h01);
        chk("R1 column 0 driven low", {24'd0, col_drive_n}, 32'hFE);
        repeat (SLOT) @(posedge clk);
        #1;
        chk("R1 column 1 after one slot", {24'd0, col_oe}, 32'h02);

        // table walk: R3 R4 R5
        for (int i = 0; i < NV; i++) begin
            pressed = TBL[i].keys;
            wait_frames(5);
            chk($sformatf("R4 vec%0d key0_valid", i), 32'(key0_valid), 32'(TBL[i].v0));
            chk($sformatf("R4 vec%0d key0_code", i), 32'(key0_code), 32'(TBL[i].c0));
            chk($sformatf("R4 vec%0d key1_valid", i), 32'(key1_valid), 32'(TBL[i].v1));
            chk($sformatf("R4 vec%0d key1_code", i), 32'(key1_code), 32'(TBL[i].c1));
            chk($sformatf("R3 R5 vec%0d key_irq", i), 32'(key_irq), 32'(TBL[i].irq));
            clr_key();
            chk($sformatf("R9 vec%0d key_irq cleared", i), 32'(key_irq), 0);
        end

        // R6 chord: reset_irq set, codes untouched
        pressed = (64'h1 << 10) | (64'h1 << 20) | (64'h1 << 30);
        wait_frames(5);
        chk("R6 chord reset_irq", 32'(reset_irq), 1);
        chk("R6 chord key_irq", 32'(key_irq), 0);
        chk("R6 chord codes kept", 32'(key0_code), 17);
        clr_reset();
        chk("R9 reset_irq cleared", 32'(reset_irq), 0);
        wait_frames(6);
        chk("R6 held chord no refire", 32'(reset_irq), 0);
        pressed = '0;
        wait_frames(5);
        clr_key();
        pressed = (64'h1 << 10) | (64'h1 << 20) | (64'h1 << 30);
        wait_frames(5);
        chk("R6 chord refires", 32'(reset_irq), 1);
        clr_reset();
        pressed = '0;
        wait_frames(5);
        clr_key();

        // R2 bouncing key never settles
        for (int f = 0; f < 8; f++) begin
            pressed = (f % 2 == 0) ? (64'h1 << 44) : 64'h0;
            wait_frames(1);
        end
        chk("R2 bounce no irq", 32'(key_irq), 0);
        chk("R2 bounce no code", 32'(key0_valid), 0);

        // R2 raised threshold: 4 pass times is short of 6
        pressed = '0;
        wait_frames(3);
        stable_scans = 4'd6;
        pressed = 64'h1 << 27;
        wait_frames(4);
        chk("R2 N=6 not yet", 32'(key_irq), 0);
        wait_frames(5);
        chk("R2 N=6 settles", 32'(key_irq), 1);
        chk("R2 N=6 code", 32'(key0_code), 27);
        clr_key();
        stable_scans = 4'd0;

        // R7 disabled: pins released, rows ignored, state held
        enable = 1'b0;
        pressed = 64'h1 << 5;
        wait_frames(6);
        chk("R7 col_oe released", 32'(col_oe), 0);
        chk("R7 col_drive_n high", {24'd0, col_drive_n}, 32'hFF);
        chk("R7 no irq while off", 32'(key_irq), 0);
        chk("R7 code held", 32'(key0_code), 27);
        enable = 1'b1;
        wait_frames(5);
        chk("R7 resumes after enable", 32'(key0_code), 5);
        chk("R7 resume irq", 32'(key_irq), 1);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule